// File: doc/BRIEF.md
# Machine Cycle, Retire and Timer Counter Unit

This unit keeps the machine-level cycle counter, the retired-instruction counter and the timer compare value for a single-hart core. The pipeline drives two increment strobes: one that is high on every counted clock and one that pulses once for each retired instruction. Software reaches every register through a single CSR port. The port takes a write enable, a 12-bit address and a write-data word, and it returns read data combinationally from the current register state.

There is no free-running time base of its own. Reading the time address returns the cycle counter, and the timer interrupt request is raised from that value against the compare register. A two-bit inhibit register can freeze each counter on its own. The counter-enable address reads as zero, and so does every address that does not decode.

Top module: `ctr_timer_unit`

## Requirements
- R1: After reset, both counters read 0, the inhibit register reads 0, the compare register reads all ones and `timer_irq_o` is low.
- R2: The cycle counter (address 0xB00) increases by one on each clock where `cycle_tick_i` is high and its inhibit bit is clear. It wraps from all ones to zero.
- R3: The retire counter (address 0xB02) increases by one on each clock where `retire_i` is high and its inhibit bit is clear.
- R4: While inhibit bit 0 is set, the cycle counter holds its value. While inhibit bit 2 is set, the retire counter holds its value.
- R5: The inhibit register (address 0x320) stores only bits 0 and 2. All other bits read zero, whatever is written.
- R6: A CSR write to a counter takes priority over that cycle's increment. The written value reads back on the next cycle.
- R7: The time address (0xC01) reads the current cycle counter. Writes to it change nothing.
- R8: `timer_irq_o` is high exactly while the cycle counter is greater than or equal to the compare register, compared unsigned.
- R9: The counter-enable address (0x306) and every unmapped address read zero. Writes to them change no register.
- R10: The compare register (address 0x7C0) is fully readable and writable at 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cycle_tick_i | input | 1 | Cycle count strobe |
| retire_i | input | 1 | One pulse per retired instruction |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data for the addressed register |
| timer_irq_o | output | 1 | Machine timer interrupt request |

## Verification
The counters are driven three ways: with a continuous tick, with an alternating retire pattern, and with every increment held off by the inhibit bits. This separates true counting from stuck or shared counters, and it shows that each inhibit bit reaches only its own counter. Writes land in the same cycles as increments, so a design that lets the increment win, or that adds one on top of the written value, is exposed. Compare values are placed just ahead of the counter, at zero and with the top bit set, which tells an unsigned compare apart from a signed or off-by-one one. A run up to the all-ones wrap confirms the rollover.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   // Register selected by a CSR address.
   typedef enum logic [2:0] {
      SEL_NONE    = 3'd0,
      SEL_CYCLE   = 3'd1,
      SEL_RETIRE  = 3'd2,
      SEL_TIME    = 3'd3,
      SEL_CMP     = 3'd4,
      SEL_INHIBIT = 3'd5,
      SEL_CNTEN   = 3'd6
   } ctr_sel_e;

   // Bit positions of the two freeze controls inside the inhibit word.
   localparam int unsigned INH_CY_BIT = 0;
   localparam int unsigned INH_IR_BIT = 2;

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
   import ctr_pkg::*;
#(
   parameter int unsigned             ADDR_W       = 12,
   parameter logic [ADDR_W-1:0]       ADDR_CYCLE   = 12'hB00,
   parameter logic [ADDR_W-1:0]       ADDR_RETIRE  = 12'hB02,
   parameter logic [ADDR_W-1:0]       ADDR_TIME    = 12'hC01,
   parameter logic [ADDR_W-1:0]       ADDR_CMP     = 12'h7C0,
   parameter logic [ADDR_W-1:0]       ADDR_INHIBIT = 12'h320,
   parameter logic [ADDR_W-1:0]       ADDR_CNTEN   = 12'h306
) (
   input  logic [ADDR_W-1:0] addr_i,
   output ctr_sel_e          sel_o
);

   always_comb begin
      if (addr_i == ADDR_CYCLE)        sel_o = SEL_CYCLE;
      else if (addr_i == ADDR_RETIRE)  sel_o = SEL_RETIRE;
      else if (addr_i == ADDR_TIME)    sel_o = SEL_TIME;
      else if (addr_i == ADDR_CMP)     sel_o = SEL_CMP;
      else if (addr_i == ADDR_INHIBIT) sel_o = SEL_INHIBIT;
      else if (addr_i == ADDR_CNTEN)   sel_o = SEL_CNTEN;
      else                             sel_o = SEL_NONE;
   end

endmodule

// File: rtl/ctr_counter.sv
module ctr_counter #(
   parameter int unsigned W = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         inc_i,
   input  logic         hold_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   if (W < 2) begin : g_bad_width
      $error("ctr_counter: W must be at least 2");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;       // software write wins over the step
      else if (inc_i && !hold_i)
         cnt_q <= cnt_q + ONE;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/ctr_inhibit_reg.sv
module ctr_inhibit_reg
   import ctr_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic         wr_cy_i,
   input  logic         wr_ir_i,
   output logic         cy_inh_o,
   output logic         ir_inh_o,
   output logic [W-1:0] rd_val_o
);

   if (W <= INH_IR_BIT) begin : g_bad_width
      $error("ctr_inhibit_reg: W too narrow for inhibit bits");
   end

   logic cy_q;
   logic ir_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cy_q <= 1'b0;
         ir_q <= 1'b0;
      end else if (we_i) begin
         cy_q <= wr_cy_i;
         ir_q <= wr_ir_i;
      end
   end

   always_comb begin
      rd_val_o             = '0;
      rd_val_o[INH_CY_BIT] = cy_q;
      rd_val_o[INH_IR_BIT] = ir_q;
   end

   assign cy_inh_o = cy_q;
   assign ir_inh_o = ir_q;

endmodule

// File: rtl/ctr_compare.sv
module ctr_compare #(
   parameter int unsigned W       = 64,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] time_i,
   output logic [W-1:0] cmp_o,
   output logic         irq_o
);

   logic [W-1:0] cmp_q;
   logic         ge;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cmp_q <= '1;
      else if (we_i)
         cmp_q <= wdata_i;
   end

   assign ge    = (time_i >= cmp_q);   // unsigned
   assign cmp_o = cmp_q;

   if (REG_OUT) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= ge;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = ge;
   end

endmodule

// File: rtl/ctr_timer_unit.sv
module ctr_timer_unit
   import ctr_pkg::*;
#(
   parameter int unsigned       CNT_W        = 64,
   parameter int unsigned       ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] ADDR_CYCLE   = 12'hB00,
   parameter logic [ADDR_W-1:0] ADDR_RETIRE  = 12'hB02,
   parameter logic [ADDR_W-1:0] ADDR_TIME    = 12'hC01,
   parameter logic [ADDR_W-1:0] ADDR_CMP     = 12'h7C0,
   parameter logic [ADDR_W-1:0] ADDR_INHIBIT = 12'h320,
   parameter logic [ADDR_W-1:0] ADDR_CNTEN   = 12'h306,
   parameter bit                IRQ_REG_OUT  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cycle_tick_i,
   input  logic              retire_i,
   input  logic              csr_we_i,
   input  logic [ADDR_W-1:0] csr_addr_i,
   input  logic [CNT_W-1:0]  csr_wdata_i,
   output logic [CNT_W-1:0]  csr_rdata_o,
   output logic              timer_irq_o
);

   if (CNT_W < 8) begin : g_bad_cnt_w
      $error("ctr_timer_unit: CNT_W must be at least 8");
   end
   if (ADDR_CYCLE == ADDR_RETIRE || ADDR_CYCLE == ADDR_TIME ||
       ADDR_CYCLE == ADDR_CMP    || ADDR_RETIRE == ADDR_TIME ||
       ADDR_RETIRE == ADDR_CMP   || ADDR_TIME == ADDR_CMP   ||
       ADDR_INHIBIT == ADDR_CNTEN) begin : g_bad_addr
      $error("ctr_timer_unit: CSR addresses must be distinct");
   end

   ctr_sel_e         sel;
   logic [CNT_W-1:0] cyc_q;
   logic [CNT_W-1:0] ret_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] inh_rd;
   logic             inh_cy;
   logic             inh_ir;
   logic             wr_cyc;
   logic             wr_ret;
   logic             wr_cmp;
   logic             wr_inh;

   ctr_addr_decode #(
      .ADDR_W      (ADDR_W),
      .ADDR_CYCLE  (ADDR_CYCLE),
      .ADDR_RETIRE (ADDR_RETIRE),
      .ADDR_TIME   (ADDR_TIME),
      .ADDR_CMP    (ADDR_CMP),
      .ADDR_INHIBIT(ADDR_INHIBIT),
      .ADDR_CNTEN  (ADDR_CNTEN)
   ) u_dec (
      .addr_i(csr_addr_i),
      .sel_o (sel)
   );

   // Time and counter-enable selects have no write strobe: read-only.
   assign wr_cyc = csr_we_i && (sel == SEL_CYCLE);
   assign wr_ret = csr_we_i && (sel == SEL_RETIRE);
   assign wr_cmp = csr_we_i && (sel == SEL_CMP);
   assign wr_inh = csr_we_i && (sel == SEL_INHIBIT);

   ctr_inhibit_reg #(.W(CNT_W)) u_inh (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_inh),
      .wr_cy_i (csr_wdata_i[INH_CY_BIT]),
      .wr_ir_i (csr_wdata_i[INH_IR_BIT]),
      .cy_inh_o(inh_cy),
      .ir_inh_o(inh_ir),
      .rd_val_o(inh_rd)
   );

   ctr_counter #(.W(CNT_W)) u_cyc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (wr_cyc),
      .load_val_i(csr_wdata_i),
      .inc_i     (cycle_tick_i),
      .hold_i    (inh_cy),
      .cnt_o     (cyc_q)
   );

   ctr_counter #(.W(CNT_W)) u_ret (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (wr_ret),
      .load_val_i(csr_wdata_i),
      .inc_i     (retire_i),
      .hold_i    (inh_ir),
      .cnt_o     (ret_q)
   );

   // The time base is the cycle counter itself.
   ctr_compare #(.W(CNT_W), .REG_OUT(IRQ_REG_OUT)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_cmp),
      .wdata_i(csr_wdata_i),
      .time_i (cyc_q),
      .cmp_o  (cmp_q),
      .irq_o  (timer_irq_o)
   );

   always_comb begin
      unique case (sel)
         SEL_CYCLE,
         SEL_TIME:    csr_rdata_o = cyc_q;
         SEL_RETIRE:  csr_rdata_o = ret_q;
         SEL_CMP:     csr_rdata_o = cmp_q;
         SEL_INHIBIT: csr_rdata_o = inh_rd;
         default:     csr_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/ctr_timer_unit_chk.sv
module ctr_timer_unit_chk #(
   parameter int unsigned       CNT_W        = 64,
   parameter int unsigned       ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] ADDR_CYCLE   = 12'hB00,
   parameter logic [ADDR_W-1:0] ADDR_RETIRE  = 12'hB02,
   parameter logic [ADDR_W-1:0] ADDR_TIME    = 12'hC01,
   parameter logic [ADDR_W-1:0] ADDR_CMP     = 12'h7C0,
   parameter logic [ADDR_W-1:0] ADDR_CNTEN   = 12'h306,
   parameter bit                IRQ_REG_OUT  = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cycle_tick_i,
   input logic              retire_i,
   input logic              csr_we_i,
   input logic [ADDR_W-1:0] csr_addr_i,
   input logic [CNT_W-1:0]  csr_wdata_i,
   input logic [CNT_W-1:0]  csr_rdata_o,
   input logic              timer_irq_o,
   input logic [CNT_W-1:0]  cyc_q,
   input logic [CNT_W-1:0]  ret_q,
   input logic              inh_cy,
   input logic              inh_ir
);

   logic wr_c, wr_r, wr_m;
   assign wr_c = csr_we_i && (csr_addr_i == ADDR_CYCLE);
   assign wr_r = csr_we_i && (csr_addr_i == ADDR_RETIRE);
   assign wr_m = csr_we_i && (csr_addr_i == ADDR_CMP);

   AST_CYCLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cycle_tick_i && !inh_cy && !wr_c) |=> (cyc_q == $past(cyc_q) + 1'b1)); // R2

   AST_RETIRE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (retire_i && !inh_ir && !wr_r) |=> (ret_q == $past(ret_q) + 1'b1)); // R3

   AST_CY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inh_cy && !wr_c) |=> $stable(cyc_q)); // R4

   AST_IR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inh_ir && !wr_r) |=> $stable(ret_q)); // R4

   AST_CYCLE_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_c |=> (cyc_q == $past(csr_wdata_i))); // R6

   AST_RETIRE_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_r |=> (ret_q == $past(csr_wdata_i))); // R6

   AST_TIME_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == ADDR_TIME) |-> (csr_rdata_o == cyc_q)); // R7

   AST_CNTEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == ADDR_CNTEN) |-> (csr_rdata_o == '0)); // R9

   if (!IRQ_REG_OUT) begin : g_irq_chk
      AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (timer_irq_o && !wr_c && !wr_m && (cyc_q != '1)) |=> timer_irq_o); // R8
   end

endmodule

bind ctr_timer_unit ctr_timer_unit_chk #(
   .CNT_W      (CNT_W),
   .ADDR_W     (ADDR_W),
   .ADDR_CYCLE (ADDR_CYCLE),
   .ADDR_RETIRE(ADDR_RETIRE),
   .ADDR_TIME  (ADDR_TIME),
   .ADDR_CMP   (ADDR_CMP),
   .ADDR_CNTEN (ADDR_CNTEN),
   .IRQ_REG_OUT(IRQ_REG_OUT)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cycle_tick_i(cycle_tick_i),
   .retire_i    (retire_i),
   .csr_we_i    (csr_we_i),
   .csr_addr_i  (csr_addr_i),
   .csr_wdata_i (csr_wdata_i),
   .csr_rdata_o (csr_rdata_o),
   .timer_irq_o (timer_irq_o),
   .cyc_q       (cyc_q),
   .ret_q       (ret_q),
   .inh_cy      (inh_cy),
   .inh_ir      (inh_ir)
);

// File: tb/ctr_timer_unit_test.sv
`timescale 1ns/1ps
module ctr_timer_unit_test;

   localparam logic [11:0] A_CYC = 12'hB00;
   localparam logic [11:0] A_RET = 12'hB02;
   localparam logic [11:0] A_TIM = 12'hC01;
   localparam logic [11:0] A_CMP = 12'h7C0;
   localparam logic [11:0] A_INH = 12'h320;
   localparam logic [11:0] A_CEN = 12'h306;
   localparam logic [11:0] A_BAD = 12'h123;
   localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        tick = 1'b0;
   logic        ret = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = 12'h000;
   logic [63:0] wdata = 64'd0;
   logic [63:0] rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   // Reference state
   logic [63:0] m_cyc = 64'd0;
   logic [63:0] m_ret = 64'd0;
   logic [63:0] m_cmp = ONES;
   logic        m_cy  = 1'b0;
   logic        m_ir  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   ctr_timer_unit uut (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .cycle_tick_i(tick),
      .retire_i    (ret),
      .csr_we_i    (we),
      .csr_addr_i  (addr),
      .csr_wdata_i (wdata),
      .csr_rdata_o (rdata),
      .timer_irq_o (irq)
   );

   function automatic logic [63:0] exp_rd(input logic [11:0] a);
      case (a)
         A_CYC, A_TIM: return m_cyc;
         A_RET:        return m_ret;
         A_CMP:        return m_cmp;
         A_INH:        return {61'd0, m_ir, 1'b0, m_cy};
         default:      return 64'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive one cycle, check the combinational read and irq, then advance the model.
   task automatic step(input logic w, input logic [11:0] a, input logic [63:0] d,
                       input logic ci, input logic ri, input string tag);
      we = w; addr = a; wdata = d; tick = ci; ret = ri;
      #1;
      check(tag, rdata, exp_rd(a));
      check("R8", {63'd0, irq}, {63'd0, (m_cyc >= m_cmp)});
      @(posedge clk);
      begin
         logic [63:0] n_cyc, n_ret;
         n_cyc = m_cyc; n_ret = m_ret;
         if (w && a == A_CYC) n_cyc = d;
         else if (ci && !m_cy) n_cyc = m_cyc + 64'd1;
         if (w && a == A_RET) n_ret = d;
         else if (ri && !m_ir) n_ret = m_ret + 64'd1;
         if (w && a == A_CMP) m_cmp = d;
         if (w && a == A_INH) begin m_cy = d[0]; m_ir = d[2]; end
         m_cyc = n_cyc; m_ret = n_ret;
      end
      @(negedge clk);
      we = 1'b0;
   endtask

   initial begin
      #(8ns * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);

      // R1: reset values
      step(0, A_CYC, 0, 0, 0, "R1");
      step(0, A_RET, 0, 0, 0, "R1");
      step(0, A_INH, 0, 0, 0, "R1");
      step(0, A_CMP, 0, 0, 0, "R1");

      // R2: continuous tick
      for (int i = 0; i < 20; i++) step(0, A_CYC, 0, 1, 0, "R2");
      // R3: alternating retire pulses
      for (int i = 0; i < 16; i++) step(0, A_RET, 0, 0, i[0], "R3");

      // R5: only bits 0 and 2 stick
      step(1, A_INH, ONES, 0, 0, "R5");
      step(0, A_INH, 0, 0, 0, "R5");
      // R4: both frozen
      for (int i = 0; i < 6; i++) step(0, A_CYC, 0, 1, 1, "R4");
      for (int i = 0; i < 6; i++) step(0, A_RET, 0, 1, 1, "R4");
      // R4: only IR frozen; cycle runs, retire holds
      step(1, A_INH, 64'h4, 1, 1, "R5");
      for (int i = 0; i < 5; i++) step(0, A_CYC, 0, 1, 1, "R4");
      for (int i = 0; i < 5; i++) step(0, A_RET, 0, 1, 1, "R4");
      // R4: only CY frozen
      step(1, A_INH, 64'h1, 1, 1, "R5");
      for (int i = 0; i < 5; i++) step(0, A_CYC, 0, 1, 1, "R4");
      for (int i = 0; i < 5; i++) step(0, A_RET, 0, 1, 1, "R4");
      step(1, A_INH, 64'h2, 1, 1, "R5");
      step(0, A_INH, 0, 1, 1, "R5");

      // R6: write in the same cycle as increments
      step(1, A_CYC, 64'h0123_4567_89AB_CDEF, 1, 1, "R6");
      step(0, A_CYC, 0, 1, 1, "R6");
      step(1, A_RET, 64'h8000_0000_0000_0010, 1, 1, "R6");
      step(0, A_RET, 0, 1, 0, "R6");

      // R2: wrap from all ones
      step(1, A_CYC, ONES - 64'd2, 0, 0, "R2");
      for (int i = 0; i < 5; i++) step(0, A_CYC, 0, 1, 0, "R2");

      // R7: time alias, writes ignored
      step(0, A_TIM, 0, 1, 0, "R7");
      step(1, A_TIM, 64'hDEAD, 1, 0, "R7");
      step(0, A_CYC, 0, 0, 0, "R7");
      step(0, A_TIM, 0, 0, 0, "R7");

      // R8 / R10: compare just ahead of the counter
      step(1, A_CYC, 64'd100, 0, 0, "R6");
      step(1, A_CMP, 64'd104, 0, 0, "R10");
      step(0, A_CMP, 0, 0, 0, "R10");
      for (int i = 0; i < 8; i++) step(0, A_TIM, 0, 1, 0, "R8");
      // unsigned: top bit set compare must not fire
      step(1, A_CMP, 64'h8000_0000_0000_0000, 1, 0, "R10");
      for (int i = 0; i < 3; i++) step(0, A_CMP, 0, 1, 0, "R8");
      step(1, A_CMP, 64'd0, 0, 0, "R10");
      step(0, A_CMP, 0, 0, 0, "R8");
      step(1, A_CYC, 64'h8000_0000_0000_0001, 0, 0, "R6");
      step(1, A_CMP, 64'h8000_0000_0000_0000, 0, 0, "R10");
      step(0, A_CMP, 0, 0, 0, "R8");

      // R9: counter-enable and unmapped read zero, writes do nothing
      step(1, A_CEN, ONES, 0, 0, "R9");
      step(0, A_CEN, 0, 0, 0, "R9");
      step(1, A_BAD, ONES, 0, 0, "R9");
      step(0, A_BAD, 0, 0, 0, "R9");
      step(0, A_CYC, 0, 0, 0, "R9");
      step(0, A_RET, 0, 0, 0, "R9");
      step(0, A_CMP, 0, 0, 0, "R9");
      step(0, A_INH, 0, 0, 0, "R9");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule